// File: doc/BRIEF.md
# ADC Sample-Trigger and Result-Formatting Controller

This block is the digital control unit in front of a successive-approximation converter core. The core is modelled here as a stub with a fixed latency. Software or hardware opens a sampling window. A programmable trigger source then closes that window and fires a single-cycle conversion-start pulse. When the core completes, the block raises a sticky done flag and stores a 16-bit output word. That word is built from the raw code in one of four justification and sign styles.

Two resolutions are supported: a 12-bit single-channel mode and a 10-bit four-channel mode. The resolution changes how the output word is packed. The trigger can be:
- software ending the window,
- a synchronised rising edge on an external pin,
- either of two timer compare pulses,
- a PWM interval pulse,
- an internal counter that ends sampling after a programmed number of cycles.

A stop-in-idle control freezes the block while the device idle request is high. Turning the module off abandons any sampling window and any conversion in flight.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While `mod_on` is 0, `sampling` is cleared within one cycle, `samp_set` has no effect and `conv_start` stays low. `done` and `result` keep their values.
- R2: With `trig_src` = 000, a `samp_clr` pulse while sampling fires `conv_start` on the next cycle. With any other code, `samp_clr` ends sampling without a conversion.
- R3: With `trig_src` = 001, `ext_pin` passes through a two-flop synchroniser. Only a rising edge ends sampling, so a held-high level gives one start and a falling edge gives none.
- R4: Code 010 selects `tmr_a_evt`, code 100 selects `tmr_b_evt` and code 011 selects `pwm_evt`. A pulse on an unselected source, or a pulse while not sampling, has no effect.
- R5: With `trig_src` = 111, sampling stays high for exactly `auto_period` cycles and then ends with a start. A period of 0 behaves as 1.
- R6: The reserved codes 101 and 110 never start a conversion. Sampling stays high until it is cleared.
- R7: `ain_code` is captured on the clock edge that raises `conv_start`. `done` and `result` update on the CONV_LAT+1-th following rising edge.
- R8: `done` stays set until `done_clr` is pulsed. A completion in the same cycle as `done_clr` takes priority.
- R9: After a completion, `sampling` re-asserts only if `auto_resample` is 1.
- R10: In 10-bit mode (`res12_mode` = 0) only `ain_code[9:0]` is used, and `out_fmt` selects the output word:
  - 00 zero-extends the code.
  - 01 gives the code minus 512, sign-extended.
  - 10 shifts the code left by 6.
  - 11 shifts the code minus 512 left by 6.
- R11: In 12-bit mode `out_fmt` selects the output word:
  - 00 zero-extends the code.
  - 01 gives the code minus 2048, sign-extended.
  - 10 shifts the code left by 4.
  - 11 shifts the code minus 2048 left by 4.
- R12: With `halt_in_idle` = 1 and `idle_req` = 1, the sampling state, the auto counter and any conversion in flight hold, and no start is issued. With `halt_in_idle` = 0, `idle_req` has no effect.
- R13: `conv_start` is a single-cycle pulse. `sampling` is low while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_on | input | 1 | Module enable |
| halt_in_idle | input | 1 | Freeze while idle is requested |
| idle_req | input | 1 | Device idle request |
| res12_mode | input | 1 | 1 = 12-bit, 0 = 10-bit |
| out_fmt | input | 2 | Output word style |
| trig_src | input | 3 | Trigger source code |
| auto_period | input | 5 | Auto-convert sampling length in cycles |
| auto_resample | input | 1 | Restart sampling after each completion |
| samp_set | input | 1 | Software pulse to begin sampling |
| samp_clr | input | 1 | Software pulse to end sampling |
| done_clr | input | 1 | Software pulse to clear done |
| tmr_a_evt | input | 1 | First timer compare pulse |
| tmr_b_evt | input | 1 | Second timer compare pulse |
| pwm_evt | input | 1 | PWM interval pulse |
| ext_pin | input | 1 | Asynchronous external trigger pin |
| ain_code | input | 12 | Code presented by the converter model |
| conv_start | output | 1 | Conversion-start pulse |
| sampling | output | 1 | Sampling window active |
| done | output | 1 | Conversion complete flag |
| result | output | 16 | Formatted result word |

## Verification
The bench drives each of the six trigger codes and both reserved codes. For each, it fires the selected source, every unselected source and the sources while not sampling, which separates correct source decoding from any-pulse triggering. The pin trigger is tried with a held-high level and with a falling edge, which distinguishes edge detection from level detection. Mid-scale and off-centre codes are converted in all four formats at both resolutions, which exposes a wrong shift, a missed MSB inversion or upper bits leaking through in 10-bit mode. Idle freezing, module-off and auto-period values 5 and 0 check that timing holds exactly, cycle by cycle, against the reference model.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    TS_SOFT  = 3'b000,
    TS_PIN   = 3'b001,
    TS_TMR_A = 3'b010,
    TS_PWM   = 3'b011,
    TS_TMR_B = 3'b100,
    TS_AUTO  = 3'b111
  } trig_src_e;

  typedef enum logic [1:0] {
    FMT_UINT  = 2'b00,
    FMT_SINT  = 2'b01,
    FMT_UFRAC = 2'b10,
    FMT_SFRAC = 2'b11
  } out_fmt_e;
endpackage

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
  import adc_seq_pkg::*;
#(
  parameter int PER_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mod_on,
  input  logic             act,
  input  logic             samp,
  input  logic             busy,
  input  logic [2:0]       sel,
  input  logic             sw_clr,
  input  logic             tmr_a,
  input  logic             tmr_b,
  input  logic             pwm,
  input  logic             pin,
  input  logic [PER_W-1:0] period,
  output logic             fire,
  output logic             abort
);
  localparam int SYNC_N = 3;

  logic [SYNC_N-1:0] sync_q;
  logic              pin_rise;
  logic [PER_W-1:0]  cnt_q;
  logic [PER_W-1:0]  per_eff;
  logic              hit;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_N-2:0], pin};
  end
  assign pin_rise = sync_q[1] & ~sync_q[2];

  assign per_eff = (period == '0) ? PER_W'(1) : period;

  always_ff @(posedge clk) begin
    if (rst || !mod_on) cnt_q <= '0;
    else if (act) cnt_q <= (samp && sel == TS_AUTO) ? cnt_q + PER_W'(1) : '0;
  end

  always_comb begin
    case (trig_src_e'(sel))
      TS_SOFT:  hit = sw_clr;
      TS_PIN:   hit = pin_rise;
      TS_TMR_A: hit = tmr_a;
      TS_PWM:   hit = pwm;
      TS_TMR_B: hit = tmr_b;
      TS_AUTO:  hit = (cnt_q >= per_eff - PER_W'(1));
      default:  hit = 1'b0;
    endcase
  end

  assign fire  = act && samp && !busy && hit;
  assign abort = act && samp && sw_clr && (sel != TS_SOFT);

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (act && samp && sel == TS_AUTO && !busy && cnt_q >= per_eff - PER_W'(1)) |-> fire);
endmodule

// File: rtl/adc_conv_stub.sv
module adc_conv_stub #(
  parameter int CODE_W   = 12,
  parameter int CONV_LAT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              clr,
  input  logic              start,
  input  logic [CODE_W-1:0] ain,
  output logic              busy,
  output logic              cmpl,
  output logic [CODE_W-1:0] raw
);
  localparam int CW = $clog2(CONV_LAT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      busy  <= 1'b0;
      cmpl  <= 1'b0;
      cnt_q <= '0;
      if (rst) raw <= '0;
    end else if (en) begin
      cmpl <= 1'b0;
      if (start) begin
        busy  <= 1'b1;
        cnt_q <= '0;
        raw   <= ain;
      end else if (busy) begin
        if (cnt_q == CW'(CONV_LAT - 1)) begin
          busy <= 1'b0;
          cmpl <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  // R7
  cmpl_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cmpl |-> !busy);
  // R7
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (start && en && !clr) |=> busy);
endmodule

// File: rtl/adc_res_fmt.sv
module adc_res_fmt
  import adc_seq_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int LO_W   = 10,
  parameter int OUT_W  = 16
) (
  input  logic              mode12,
  input  logic [1:0]        fmt,
  input  logic [CODE_W-1:0] raw,
  output logic [OUT_W-1:0]  word
);
  localparam int SH_HI = OUT_W - CODE_W;
  localparam int SH_LO = OUT_W - LO_W;

  logic [CODE_W-1:0] h_off, h_flip;
  logic [LO_W-1:0]   l_off, l_flip;

  assign h_off  = raw;
  assign h_flip = {~raw[CODE_W-1], raw[CODE_W-2:0]};
  assign l_off  = raw[LO_W-1:0];
  assign l_flip = {~raw[LO_W-1], raw[LO_W-2:0]};

  always_comb begin
    case (out_fmt_e'(fmt))
      FMT_UINT:  word = mode12 ? {{SH_HI{1'b0}}, h_off} : {{SH_LO{1'b0}}, l_off};
      FMT_SINT:  word = mode12 ? {{SH_HI{h_flip[CODE_W-1]}}, h_flip}
                               : {{SH_LO{l_flip[LO_W-1]}}, l_flip};
      FMT_UFRAC: word = mode12 ? {h_off, {SH_HI{1'b0}}} : {l_off, {SH_LO{1'b0}}};
      default:   word = mode12 ? {h_flip, {SH_HI{1'b0}}} : {l_flip, {SH_LO{1'b0}}};
    endcase
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int CODE_W   = 12,
  parameter int LO_W     = 10,
  parameter int OUT_W    = 16,
  parameter int PER_W    = 5,
  parameter int CONV_LAT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mod_on,
  input  logic              halt_in_idle,
  input  logic              idle_req,
  input  logic              res12_mode,
  input  logic [1:0]        out_fmt,
  input  logic [2:0]        trig_src,
  input  logic [PER_W-1:0]  auto_period,
  input  logic              auto_resample,
  input  logic              samp_set,
  input  logic              samp_clr,
  input  logic              done_clr,
  input  logic              tmr_a_evt,
  input  logic              tmr_b_evt,
  input  logic              pwm_evt,
  input  logic              ext_pin,
  input  logic [CODE_W-1:0] ain_code,
  output logic              conv_start,
  output logic              sampling,
  output logic              done,
  output logic [OUT_W-1:0]  result
);
  logic              act, fire, abort, busy, cmpl;
  logic [CODE_W-1:0] raw;
  logic [OUT_W-1:0]  word;

  assign act = mod_on && !(halt_in_idle && idle_req);

  adc_trig_sel #(.PER_W(PER_W)) u_trig (
    .clk(clk), .rst(rst), .mod_on(mod_on), .act(act), .samp(sampling),
    .busy(busy), .sel(trig_src), .sw_clr(samp_clr), .tmr_a(tmr_a_evt),
    .tmr_b(tmr_b_evt), .pwm(pwm_evt), .pin(ext_pin), .period(auto_period),
    .fire(fire), .abort(abort)
  );

  adc_conv_stub #(.CODE_W(CODE_W), .CONV_LAT(CONV_LAT)) u_conv (
    .clk(clk), .rst(rst), .en(act), .clr(!mod_on), .start(fire),
    .ain(ain_code), .busy(busy), .cmpl(cmpl), .raw(raw)
  );

  adc_res_fmt #(.CODE_W(CODE_W), .LO_W(LO_W), .OUT_W(OUT_W)) u_fmt (
    .mode12(res12_mode), .fmt(out_fmt), .raw(raw), .word(word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sampling   <= 1'b0;
      conv_start <= 1'b0;
      done       <= 1'b0;
      result     <= '0;
    end else begin
      conv_start <= fire;
      if (act && cmpl)   done <= 1'b1;
      else if (done_clr) done <= 1'b0;
      if (!mod_on) begin
        sampling <= 1'b0;
      end else if (act) begin
        if (cmpl) begin
          result   <= word;
          sampling <= auto_resample;
        end else if (fire || abort) begin
          sampling <= 1'b0;
        end else if (samp_set && !busy) begin
          sampling <= 1'b1;
        end
      end
    end
  end

  // R13
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);
  // R13
  start_nosamp_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> !sampling);
  // R1
  off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !mod_on |=> (!conv_start && !sampling));
  // R6
  rsvd_nostart_chk: assert property (@(posedge clk) disable iff (rst)
    (trig_src == 3'b101 || trig_src == 3'b110) |=> !conv_start);
  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !done_clr) |=> done);
  // R12
  idle_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (mod_on && halt_in_idle && idle_req) |=> (!conv_start && $stable(sampling)));
endmodule

// File: tb/sim_adc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_adc_seq_ctrl;
  localparam int LAT = 4;

  logic clk = 0, rst = 1;
  logic mod_on = 0, halt_in_idle = 0, idle_req = 0, res12_mode = 0;
  logic [1:0] out_fmt = 0;
  logic [2:0] trig_src = 0;
  logic [4:0] auto_period = 0;
  logic auto_resample = 0, samp_set = 0, samp_clr = 0, done_clr = 0;
  logic tmr_a_evt = 0, tmr_b_evt = 0, pwm_evt = 0, ext_pin = 0;
  logic [11:0] ain_code = 0;
  logic conv_start, sampling, done;
  logic [15:0] result;

  int checks = 0, fails = 0, starts = 0;
  bit running = 0;
  string phase = "reset";

  always #5 clk = ~clk;

  adc_seq_ctrl #(.CONV_LAT(LAT)) u0 (
    .clk(clk), .rst(rst), .mod_on(mod_on), .halt_in_idle(halt_in_idle),
    .idle_req(idle_req), .res12_mode(res12_mode), .out_fmt(out_fmt),
    .trig_src(trig_src), .auto_period(auto_period), .auto_resample(auto_resample),
    .samp_set(samp_set), .samp_clr(samp_clr), .done_clr(done_clr),
    .tmr_a_evt(tmr_a_evt), .tmr_b_evt(tmr_b_evt), .pwm_evt(pwm_evt),
    .ext_pin(ext_pin), .ain_code(ain_code), .conv_start(conv_start),
    .sampling(sampling), .done(done), .result(result)
  );

  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
    end
  endtask

  function automatic logic [15:0] ref_fmt(bit m12, logic [1:0] f, logic [11:0] c);
    int u, s;
    u = m12 ? int'(c) : int'(c[9:0]);
    s = m12 ? u - 2048 : u - 512;
    case (f)
      2'd0: return 16'(u);
      2'd1: return 16'(s);
      2'd2: return 16'(m12 ? u * 16 : u * 64);
      default: return 16'(m12 ? s * 16 : s * 64);
    endcase
  endfunction

  // reference model
  bit m_samp, m_start, m_done;
  logic [15:0] m_res;
  logic [11:0] m_code;
  logic [2:0] m_pipe;
  int m_cnt, m_left;

  always @(posedge clk) begin
    if (rst) begin
      m_samp = 0; m_start = 0; m_done = 0; m_res = 0; m_code = 0;
      m_pipe = 0; m_cnt = 0; m_left = 0;
    end else begin
      bit act, fire, abort, rise, busy;
      int pe;
      act = mod_on && !(halt_in_idle && idle_req);
      rise = m_pipe[1] && !m_pipe[2];
      busy = m_left > 1;
      pe = (auto_period == 0) ? 1 : int'(auto_period);
      fire = 0;
      if (act && m_samp && !busy)
        case (trig_src)
          3'd0: fire = samp_clr;
          3'd1: fire = rise;
          3'd2: fire = tmr_a_evt;
          3'd3: fire = pwm_evt;
          3'd4: fire = tmr_b_evt;
          3'd7: fire = (m_cnt >= pe - 1);
          default: fire = 0;
        endcase
      abort = act && m_samp && samp_clr && trig_src != 0;
      m_pipe = {m_pipe[1:0], ext_pin};
      m_start = fire;
      if (!mod_on) begin
        m_samp = 0; m_cnt = 0; m_left = 0;
        if (done_clr) m_done = 0;
      end else if (!act) begin
        if (done_clr) m_done = 0;
      end else begin
        m_cnt = (m_samp && trig_src == 7) ? m_cnt + 1 : 0;
        if (m_left == 1) begin
          m_res = ref_fmt(res12_mode, out_fmt, m_code);
          m_done = 1; m_samp = auto_resample; m_left = 0;
        end else begin
          if (done_clr) m_done = 0;
          if (m_left > 1) m_left--;
          if (fire) begin m_samp = 0; m_left = LAT + 1; m_code = ain_code; end
          else if (abort) m_samp = 0;
          else if (samp_set && !busy) m_samp = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (conv_start) starts++;
    if (running)
      chk(conv_start === m_start && sampling === m_samp && done === m_done && result === m_res,
          phase, {conv_start, sampling, done, result}, {m_start, m_samp, m_done, m_res});
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // 0 set, 1 clr, 2 done_clr, 3 tmr_a, 4 tmr_b, 5 pwm
  task automatic hit(input int which);
    case (which)
      0: samp_set = 1; 1: samp_clr = 1; 2: done_clr = 1;
      3: tmr_a_evt = 1; 4: tmr_b_evt = 1; default: pwm_evt = 1;
    endcase
    cyc(1);
    samp_set = 0; samp_clr = 0; done_clr = 0; tmr_a_evt = 0; tmr_b_evt = 0; pwm_evt = 0;
  endtask

  task automatic run_sw(input logic [11:0] code);
    ain_code = code;
    hit(2); hit(0); cyc(2); hit(1);
    ain_code = ~code;
    cyc(LAT + 1);
  endtask

  task automatic fmt_case(input bit m12, input logic [1:0] f, input logic [11:0] code,
                          input logic [15:0] expv, input string req);
    res12_mode = m12; out_fmt = f;
    run_sw(code);
    #3;
    chk(result === expv && done === 1, req, result, expv);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int s0, n;
    cyc(3);
    rst = 0;
    #3;
    chk(conv_start === 0 && sampling === 0 && done === 0 && result === 0, "R1 reset", result, 0);
    cyc(1);
    running = 1;
    mod_on = 1;

    // R7 latency
    phase = "R7";
    res12_mode = 1; ain_code = 12'h5A3;
    hit(0); cyc(2); hit(1);
    ain_code = 12'h000;
    #3 chk(conv_start === 1, "R7 start", conv_start, 1);
    cyc(LAT);
    #3 chk(done === 0, "R7 early", done, 0);
    cyc(1);
    #3 chk(done === 1 && result === 16'h05A3, "R7 done", result, 16'h05A3);
    cyc(1);

    // R8 sticky done and clear
    phase = "R8";
    cyc(5);
    #3 chk(done === 1, "R8 hold", done, 1);
    cyc(1); hit(2);
    #3 chk(done === 0, "R8 clear", done, 0);
    cyc(1);

    // R10 / R11 formats
    phase = "R10";
    fmt_case(0, 2'd0, 12'hDA5, 16'h01A5, "R10 uint");
    fmt_case(0, 2'd1, 12'hDA5, 16'hFFA5, "R10 sint");
    fmt_case(0, 2'd2, 12'hDA5, 16'h6940, "R10 ufrac");
    fmt_case(0, 2'd3, 12'hDA5, 16'hE940, "R10 sfrac");
    phase = "R11";
    fmt_case(1, 2'd0, 12'h7F3, 16'h07F3, "R11 uint");
    fmt_case(1, 2'd1, 12'h7F3, 16'hFFF3, "R11 sint");
    fmt_case(1, 2'd2, 12'h7F3, 16'h7F30, "R11 ufrac");
    fmt_case(1, 2'd3, 12'h7F3, 16'hFF30, "R11 sfrac");
    fmt_case(1, 2'd1, 12'h800, 16'h0000, "R11 midscale");

    // R9 auto resample
    phase = "R9";
    auto_resample = 1; cyc(1);
    run_sw(12'h123); cyc(1);
    #3 chk(sampling === 1, "R9 resample on", sampling, 1);
    cyc(1); hit(1); cyc(LAT + 2);
    auto_resample = 0; cyc(1);
    run_sw(12'h321); cyc(1);
    #3 chk(sampling === 0, "R9 resample off", sampling, 0);
    cyc(1);

    // R3 pin edge
    phase = "R3";
    trig_src = 3'b001;
    hit(0); cyc(2);
    s0 = starts; ext_pin = 1; cyc(8); ext_pin = 0; cyc(LAT + 3);
    #3 chk(starts - s0 == 1, "R3 one start on level", starts - s0, 1);
    cyc(1);
    ext_pin = 1; cyc(4); hit(0); cyc(3);
    s0 = starts; ext_pin = 0; cyc(6);
    #3 chk(starts == s0 && sampling === 1, "R3 falling ignored", starts - s0, 0);
    cyc(1);
    phase = "R2";
    hit(1); cyc(2);
    #3 chk(starts == s0 && sampling === 0, "R2 clear without start", starts - s0, 0);
    cyc(1);

    // R4 timers and pwm
    phase = "R4";
    trig_src = 3'b010; s0 = starts;
    hit(3); cyc(2);
    hit(0); hit(4); hit(5); cyc(2);
    #3 chk(starts == s0, "R4 unselected ignored", starts - s0, 0);
    cyc(1); hit(3); cyc(LAT + 3);
    #3 chk(starts - s0 == 1, "R4 tmr_a", starts - s0, 1);
    cyc(1);
    trig_src = 3'b100; s0 = starts;
    hit(0); hit(3); hit(5); cyc(1); hit(4); cyc(LAT + 3);
    #3 chk(starts - s0 == 1, "R4 tmr_b", starts - s0, 1);
    cyc(1);
    trig_src = 3'b011; s0 = starts;
    hit(5); cyc(1); hit(0); hit(3); hit(4); cyc(1); hit(5); cyc(LAT + 3);
    #3 chk(starts - s0 == 1, "R4 pwm", starts - s0, 1);
    cyc(1);

    // R5 auto period
    phase = "R5";
    trig_src = 3'b111; auto_period = 5;
    hit(0);
    n = 0; #3;
    while (sampling) begin n++; @(negedge clk); end
    chk(n == 5, "R5 period 5", n, 5);
    cyc(LAT + 3);
    auto_period = 0;
    hit(0);
    n = 0; #3;
    while (sampling) begin n++; @(negedge clk); end
    chk(n == 1, "R5 period 0", n, 1);
    cyc(LAT + 3);

    // R6 reserved codes
    phase = "R6";
    for (int k = 5; k <= 6; k++) begin
      trig_src = 3'(k); s0 = starts;
      hit(0); hit(3); hit(4); hit(5);
      ext_pin = 1; cyc(5); ext_pin = 0; cyc(3);
      #3 chk(starts == s0 && sampling === 1, "R6 reserved", starts - s0, 0);
      cyc(1); hit(1); cyc(1);
    end

    // R12 idle
    phase = "R12";
    trig_src = 3'b111; auto_period = 3; halt_in_idle = 1;
    s0 = starts;
    hit(0); idle_req = 1; cyc(10);
    #3 chk(starts == s0 && sampling === 1, "R12 frozen", starts - s0, 0);
    cyc(1); idle_req = 0; cyc(LAT + 6);
    #3 chk(starts - s0 == 1, "R12 resumes", starts - s0, 1);
    cyc(1);
    halt_in_idle = 0; idle_req = 1; s0 = starts;
    hit(0); cyc(LAT + 8);
    #3 chk(starts - s0 == 1, "R12 runs in idle", starts - s0, 1);
    cyc(1); idle_req = 0;

    // R1 module off
    phase = "R1";
    trig_src = 3'b101;
    hit(0); mod_on = 0; cyc(1);
    #3 chk(sampling === 0, "R1 off clears", sampling, 0);
    cyc(1); trig_src = 3'b000; s0 = starts;
    hit(0);
    #3 chk(sampling === 0, "R1 set ignored", sampling, 0);
    cyc(1); hit(1); cyc(2);
    #3 chk(starts == s0 && done === 1, "R1 no start", starts - s0, 0);
    cyc(1); mod_on = 1;

    // R13 covered by every start above
    phase = "R13";
    hit(0); cyc(1); hit(1);
    #3 chk(conv_start === 1 && sampling === 0, "R13 start pulse", conv_start, 1);
    cyc(1);
    #3 chk(conv_start === 0, "R13 single cycle", conv_start, 0);
    cyc(LAT + 3);

    running = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule